// File: doc/BRIEF.md
# Multicycle Accumulator Processor

This block is a small accumulator machine that runs one instruction at a time through a fixed series of steps. It fetches the instruction word, decodes it, forms the effective address, reads the operand when one is needed, executes, and writes back to memory when the instruction stores something. Each step takes one clock cycle. The step sequence is held in explicit memory-address and memory-data registers. The architectural state is an accumulator, a carry flag, two index registers and a program counter. The index registers and the program counter are each as wide as the address field.

Instructions and data share one word-addressed memory inside the block. A debug port writes this memory, normally while reset is held, so that a program can be loaded. The same port reads any word back and shows the architectural registers at all times. When the program executes a halt, the sequencer stops and the halt output stays high until the next reset.

Top module: `acc_core`

## Requirements
- R1: While reset is low, the program counter, accumulator, carry flag and both index registers read zero and `halted` is low. After a second reset they return to zero, whatever a previous run left in them.
- R2: An instruction word holds the opcode in bits [17:15], the addressing mode in bits [14:13] and the address field in bits [12:0]. Each instruction passes through fetch, decode, address and execute, plus an operand-read cycle when it reads memory and a store cycle when it writes memory. The program counter increments by one at the end of the fetch cycle.
- R3: Mode 00 is direct: the operand is M[a], where a is the address field. Mode 01 is indirect: the operand is M[M[a][12:0]]. Mode 10 is indexed: the operand is M[a + index register A]. Mode 11 is immediate: the operand is the address field itself, zero-extended. In opcode groups 101 and 110, a is field bits [10:0], and field bits [12:11] select the variant. Memory addresses wrap modulo the memory depth.
- R4: Opcode 000 loads the operand into the accumulator. Opcode 100 ANDs the operand into the accumulator. In group 101, variant 00 is OR, variant 01 inverts the accumulator without reading an operand, variant 10 loads index register A from operand bits [12:0], and variant 11 loads index register B the same way.
- R5: Opcode 010 adds the operand to the accumulator. Opcode 011 subtracts it in two's complement, as acc + ~operand + 1. Both write the carry-out of the 18-bit sum to the carry flag. No other instruction changes the carry flag.
- R6: In group 110, variant 00 jumps to the effective address. Variant 01 jumps there only when the carry flag is 1, and otherwise continues with the next instruction.
- R7: In group 110, variant 10 is a call. It writes the address of the next instruction to M[ea] and continues at ea+1. Variant 11 is a return. It continues at the address held in bits [12:0] of the operand.
- R8: Opcode 001 writes the accumulator to M[ea] in its store cycle and leaves the registers unchanged.
- R9: Opcode 111 raises `halted` at the end of its decode cycle. From then until reset, no register or memory word changes.
- R10: A debug write stores `dbg_wdata` at `dbg_addr`. `dbg_rdata` shows the memory word at `dbg_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halted | output | 1 | High once a halt instruction has been decoded |
| dbg_we | input | 1 | Debug memory write enable |
| dbg_addr | input | 13 | Debug memory address |
| dbg_wdata | input | 18 | Debug memory write data |
| dbg_rdata | output | 18 | Memory word at `dbg_addr` |
| dbg_acc | output | 18 | Accumulator |
| dbg_cf | output | 1 | Carry flag |
| dbg_pc | output | 13 | Program counter |
| dbg_ia | output | 13 | Index register A |
| dbg_ib | output | 13 | Index register B |

## Verification
The assertions watch every cycle for the following rules:
- The program counter steps by one out of fetch, and decode always follows fetch.
- The accumulator and carry flag change only in the execute cycle.
- A conditional jump with the carry flag clear leaves the program counter where it was.
- Once halted, the machine stays halted and frozen.

Other behaviour shows only through the bench program, which a step-by-step reference model follows:
- the operand values that each addressing mode produces,
- the carry value after additions and subtractions,
- the call and return targets,
- the memory words that stores and calls leave behind.

// File: rtl/acc_pkg.sv
// Package: shared encodings for the accumulator machine.
// Assumes an instruction word of 3 opcode bits, 2 mode bits and an address field.
package acc_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_OPND   = 3'd3,
        ST_EXEC   = 3'd4,
        ST_STORE  = 3'd5,
        ST_HALT   = 3'd6
    } state_t;

    localparam logic [2:0] OP_LOAD  = 3'b000;
    localparam logic [2:0] OP_STORE = 3'b001;
    localparam logic [2:0] OP_ADD   = 3'b010;
    localparam logic [2:0] OP_SUB   = 3'b011;
    localparam logic [2:0] OP_AND   = 3'b100;
    localparam logic [2:0] OP_LOGIC = 3'b101;
    localparam logic [2:0] OP_FLOW  = 3'b110;
    localparam logic [2:0] OP_HALT  = 3'b111;

    localparam logic [1:0] MD_DIR = 2'b00;
    localparam logic [1:0] MD_IND = 2'b01;
    localparam logic [1:0] MD_IDX = 2'b10;
    localparam logic [1:0] MD_IMM = 2'b11;

    // variants in group 101
    localparam logic [1:0] LV_OR  = 2'b00;
    localparam logic [1:0] LV_NOT = 2'b01;
    localparam logic [1:0] LV_LDA = 2'b10;
    localparam logic [1:0] LV_LDB = 2'b11;

    // variants in group 110
    localparam logic [1:0] FV_JMP  = 2'b00;
    localparam logic [1:0] FV_JC   = 2'b01;
    localparam logic [1:0] FV_CALL = 2'b10;
    localparam logic [1:0] FV_RET  = 2'b11;

endpackage

// File: rtl/acc_mem.sv
// Module: acc_mem
// Unified program/data memory: one write port, shared between the debug
// port and the core (the debug write has priority), plus three combinational
// read ports (fetch, operand, debug). Assumes the addresses wrap modulo DEPTH.
module acc_mem #(
    parameter int DW    = 18,
    parameter int AW    = 13,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          dbg_we,
    input  logic [AW-1:0] dbg_waddr,
    input  logic [DW-1:0] dbg_wdata,
    input  logic          core_we,
    input  logic [AW-1:0] core_waddr,
    input  logic [DW-1:0] core_wdata,
    input  logic [AW-1:0] raddr_f,
    output logic [DW-1:0] rdata_f,
    input  logic [AW-1:0] raddr_o,
    output logic [DW-1:0] rdata_o,
    input  logic [AW-1:0] raddr_d,
    output logic [DW-1:0] rdata_d
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] words [DEPTH];

    // Write path: debug port first, core store second.
    always_ff @(posedge clk) begin
        if (dbg_we)
            words[dbg_waddr[IW-1:0]] <= dbg_wdata;
        else if (core_we)
            words[core_waddr[IW-1:0]] <= core_wdata;
    end

    // Read ports: asynchronous.
    always_comb begin
        rdata_f = words[raddr_f[IW-1:0]];
        rdata_o = words[raddr_o[IW-1:0]];
        rdata_d = words[raddr_d[IW-1:0]];
    end
endmodule

// File: rtl/acc_agu.sv
// Module: acc_agu
// Address evaluation: from the base address in MA, the addressing mode,
// index register A and the memory word at MA, forms the next MA value.
// Purely combinational. Direct and immediate keep the base address.
module acc_agu #(
    parameter int AW = 13
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] idx_a,
    input  logic [AW-1:0] ptr_word,
    output logic [AW-1:0] ea
);
    import acc_pkg::*;

    // Select the effective address according to the mode.
    always_comb begin
        unique case (mode)
            MD_IND:  ea = ptr_word;
            MD_IDX:  ea = base + idx_a;
            default: ea = base;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
// Module: acc_alu
// Accumulator datapath: add, subtract (two's complement, carry out of the
// DW-bit sum), AND, OR, NOT and load. Purely combinational. The caller
// decides whether the result and carry are written.
module acc_alu #(
    parameter int DW = 18
) (
    input  logic [2:0]    op,
    input  logic [1:0]    variant,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] res,
    output logic          cout
);
    import acc_pkg::*;

    logic [DW:0] sum;

    // Compute the result for the decoded operation.
    always_comb begin
        sum  = '0;
        res  = acc;
        cout = 1'b0;
        unique case (op)
            OP_LOAD: res = opnd;
            OP_ADD: begin
                sum  = {1'b0, acc} + {1'b0, opnd};
                res  = sum[DW-1:0];
                cout = sum[DW];
            end
            OP_SUB: begin
                sum  = {1'b0, acc} + {1'b0, ~opnd} + {{DW{1'b0}}, 1'b1};
                res  = sum[DW-1:0];
                cout = sum[DW];
            end
            OP_AND: res = acc & opnd;
            OP_LOGIC: res = (variant == LV_NOT) ? ~acc : (acc | opnd);
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
// Module: acc_core (top)
// Multicycle accumulator machine. Sequence per instruction:
// fetch, decode, address, [operand], execute, [store]. The memory is
// internal and the debug port loads and inspects it. Assumes the program
// is loaded while rst_n is low. Reset is synchronous, active low.
module acc_core #(
    parameter int AW    = 13,
    parameter int DEPTH = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 halted,
    input  logic                 dbg_we,
    input  logic [AW-1:0]        dbg_addr,
    input  logic [AW+4:0]        dbg_wdata,
    output logic [AW+4:0]        dbg_rdata,
    output logic [AW+4:0]        dbg_acc,
    output logic                 dbg_cf,
    output logic [AW-1:0]        dbg_pc,
    output logic [AW-1:0]        dbg_ia,
    output logic [AW-1:0]        dbg_ib
);
    import acc_pkg::*;

    localparam int DW = AW + 5;

    state_t        state;
    logic [AW-1:0] pc, ma, ia, ib;
    logic [DW-1:0] ir, md, acc;
    logic          cf;

    logic [2:0]    op;
    logic [1:0]    mode, variant;
    logic [AW-1:0] fld, base, ea;
    logic          grp, skip_opnd, needs_store, acc_wr;
    logic [DW-1:0] rd_f, rd_o, alu_res;
    logic          alu_cout;

    // Field decode of the instruction register.
    always_comb begin
        op      = ir[DW-1:DW-3];
        mode    = ir[DW-4:DW-5];
        fld     = ir[AW-1:0];
        variant = fld[AW-1:AW-2];
        grp     = (op == OP_LOGIC) || (op == OP_FLOW);
        base    = grp ? {2'b00, fld[AW-3:0]} : fld;
        skip_opnd = (mode == MD_IMM) || (op == OP_STORE)
                  || (op == OP_LOGIC && variant == LV_NOT)
                  || (op == OP_FLOW && variant != FV_RET);
        needs_store = (op == OP_STORE) || (op == OP_FLOW && variant == FV_CALL);
        acc_wr = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND)
               || (op == OP_LOGIC && (variant == LV_OR || variant == LV_NOT));
    end

    acc_mem #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_mem (
        .clk        (clk),
        .dbg_we     (dbg_we),
        .dbg_waddr  (dbg_addr),
        .dbg_wdata  (dbg_wdata),
        .core_we    (state == ST_STORE),
        .core_waddr (ma),
        .core_wdata (md),
        .raddr_f    (pc),
        .rdata_f    (rd_f),
        .raddr_o    (ma),
        .rdata_o    (rd_o),
        .raddr_d    (dbg_addr),
        .rdata_d    (dbg_rdata)
    );

    acc_agu #(.AW(AW)) u_agu (
        .mode     (mode),
        .base     (ma),
        .idx_a    (ia),
        .ptr_word (rd_o[AW-1:0]),
        .ea       (ea)
    );

    acc_alu #(.DW(DW)) u_alu (
        .op      (op),
        .variant (variant),
        .acc     (acc),
        .opnd    (md),
        .res     (alu_res),
        .cout    (alu_cout)
    );

    // Instruction sequencer and architectural register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            pc    <= '0;
            ma    <= '0;
            md    <= '0;
            ir    <= '0;
            acc   <= '0;
            cf    <= 1'b0;
            ia    <= '0;
            ib    <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= rd_f;
                    pc    <= pc + 1'b1;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    ma    <= base;
                    state <= (op == OP_HALT) ? ST_HALT : ST_ADDR;
                end
                ST_ADDR: begin
                    ma <= ea;
                    if (mode == MD_IMM)
                        md <= {{(DW-AW){1'b0}}, base};
                    state <= skip_opnd ? ST_EXEC : ST_OPND;
                end
                ST_OPND: begin
                    md    <= rd_o;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (acc_wr)
                        acc <= alu_res;
                    if (op == OP_ADD || op == OP_SUB)
                        cf <= alu_cout;
                    if (op == OP_STORE)
                        md <= acc;
                    if (op == OP_LOGIC && variant == LV_LDA)
                        ia <= md[AW-1:0];
                    if (op == OP_LOGIC && variant == LV_LDB)
                        ib <= md[AW-1:0];
                    if (op == OP_FLOW) begin
                        unique case (variant)
                            FV_JMP:  pc <= ma;
                            FV_JC:   if (cf) pc <= ma;
                            FV_CALL: begin
                                md <= {{(DW-AW){1'b0}}, pc};
                                pc <= ma + 1'b1;
                            end
                            default: pc <= md[AW-1:0];
                        endcase
                    end
                    state <= needs_store ? ST_STORE : ST_FETCH;
                end
                ST_STORE: state <= ST_FETCH;
                default:  state <= ST_HALT;
            endcase
        end
    end

    // Debug view of the architectural state.
    always_comb begin
        halted  = (state == ST_HALT);
        dbg_acc = acc;
        dbg_cf  = cf;
        dbg_pc  = pc;
        dbg_ia  = ia;
        dbg_ib  = ib;
    end
endmodule

// File: rtl/acc_core_chk.sv
// Module: acc_core_chk
// Property checker bound into acc_core. Watches the sequencer state and the
// architectural registers.
module acc_core_chk #(
    parameter int AW = 13
) (
    input logic              clk,
    input logic              rst_n,
    input acc_pkg::state_t   st,
    input logic [AW+4:0]     ir_w,
    input logic [AW-1:0]     pc,
    input logic [AW+4:0]     acc,
    input logic              cf,
    input logic              halted
);
    import acc_pkg::*;

    logic [2:0] op_w;
    logic [1:0] var_w;
    assign op_w  = ir_w[AW+4:AW+2];
    assign var_w = ir_w[AW-1:AW-2];

    // R2: the fetch cycle advances PC by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |=> (pc == AW'($past(pc) + 1'b1)));

    // R2: decode always follows fetch
    a_r2_decode_next: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |=> (st == ST_DECODE));

    // R5: the accumulator and carry change only out of execute
    a_r5_acc_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_EXEC) |=> ($stable(acc) && $stable(cf)));

    // R6: a conditional jump with the carry clear does not move PC
    a_r6_jc_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC && op_w == OP_FLOW && var_w == FV_JC && !cf) |=> $stable(pc));

    // R9: halt is sticky and freezes the registers
    a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc) && $stable(cf)));
endmodule

bind acc_core acc_core_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (state),
    .ir_w   (ir),
    .pc     (pc),
    .acc    (acc),
    .cf     (cf),
    .halted (halted)
);

// File: tb/sim_acc_core.sv
// Bench for acc_core. A behavioural reference model steps through each
// instruction and is compared with the debug outputs on every clock.
module sim_acc_core;
    localparam int AW = 13;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halted;
    logic          dbg_we = 1'b0;
    logic [AW-1:0] dbg_addr = '0;
    logic [DW-1:0] dbg_wdata = '0;
    logic [DW-1:0] dbg_rdata, dbg_acc;
    logic          dbg_cf;
    logic [AW-1:0] dbg_pc, dbg_ia, dbg_ib;

    int n_tests = 0;
    int n_fail  = 0;
    bit live_cmp = 1'b0;

    always #4 clk = ~clk;

    acc_core #(.AW(AW), .DEPTH(256)) u0 (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .dbg_acc(dbg_acc), .dbg_cf(dbg_cf),
        .dbg_pc(dbg_pc), .dbg_ia(dbg_ia), .dbg_ib(dbg_ib)
    );

    // ---------------- reference model ----------------
    logic [DW-1:0] m_mem [256];
    logic [DW-1:0] m_acc, n_acc, opnd, st_d, ir;
    logic [AW-1:0] m_pc, m_ia, m_ib, n_pc, n_ia, n_ib, base, ea, st_a;
    logic          m_cf, n_cf, m_halt, has_st, is_halt;
    logic [DW:0]   s19;
    int            ph = 0, ex_ph = 0, len = 0;
    string         tag = "R1";

    function automatic logic [DW-1:0] enc(int op, int md, int fld);
        return {op[2:0], md[1:0], fld[12:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = '0; m_acc = '0; m_cf = 1'b0; m_ia = '0; m_ib = '0;
            m_halt = 1'b0; ph = 0;
        end else if (!m_halt) begin
            if (ph == 0) begin
                logic [2:0] op; logic [1:0] md, sv; logic [12:0] f; logic skip;
                ir = m_mem[m_pc[7:0]];
                m_pc = m_pc + 1'b1;
                op = ir[17:15]; md = ir[14:13]; f = ir[12:0]; sv = f[12:11];
                base = (op == 5 || op == 6) ? {2'b00, f[10:0]} : f;
                case (md)
                    2'd1: ea = m_mem[base[7:0]][12:0];
                    2'd2: ea = base + m_ia;
                    default: ea = base;
                endcase
                opnd = (md == 3) ? {5'b0, base} : m_mem[ea[7:0]];
                skip = (md == 3) || (op == 1) || (op == 5 && sv == 1) || (op == 6 && sv != 3);
                ex_ph = skip ? 3 : 4;
                has_st = (op == 1) || (op == 6 && sv == 2);
                is_halt = (op == 7);
                len = is_halt ? 2 : ex_ph + 1 + int'(has_st);
                n_acc = m_acc; n_cf = m_cf; n_pc = m_pc; n_ia = m_ia; n_ib = m_ib;
                st_a = ea; st_d = m_acc;
                tag = "R4";
                case (op)
                    3'd0: n_acc = opnd;
                    3'd1: tag = "R8";
                    3'd2: begin s19 = {1'b0, m_acc} + {1'b0, opnd}; {n_cf, n_acc} = s19; tag = "R5"; end
                    3'd3: begin s19 = {1'b0, m_acc} + {1'b0, ~opnd} + 19'd1; {n_cf, n_acc} = s19; tag = "R5"; end
                    3'd4: n_acc = m_acc & opnd;
                    3'd5: case (sv)
                        2'd0: n_acc = m_acc | opnd;
                        2'd1: n_acc = ~m_acc;
                        2'd2: n_ia = opnd[12:0];
                        default: n_ib = opnd[12:0];
                    endcase
                    3'd6: case (sv)
                        2'd0: begin n_pc = ea; tag = "R6"; end
                        2'd1: begin if (m_cf) n_pc = ea; tag = "R6"; end
                        2'd2: begin st_d = {5'b0, m_pc}; n_pc = ea + 1'b1; tag = "R7"; end
                        default: begin n_pc = opnd[12:0]; tag = "R7"; end
                    endcase
                    default: tag = "R9";
                endcase
                if (md != 0 && op != 6 && op != 7) tag = "R3";
            end
            if (is_halt && ph == 1) m_halt = 1'b1;
            if (!is_halt && ph == ex_ph) begin
                m_acc = n_acc; m_cf = n_cf; m_pc = n_pc; m_ia = n_ia; m_ib = n_ib;
            end
            if (!is_halt && has_st && ph == ex_ph + 1) m_mem[st_a[7:0]] = st_d;
            if (ph == len - 1) ph = 0; else ph = ph + 1;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && live_cmp) begin
            n_tests++;
            if (dbg_acc !== m_acc || dbg_cf !== m_cf || dbg_ia !== m_ia || dbg_ib !== m_ib) begin
                n_fail++;
                $display("FAIL %s regs: acc=%h cf=%b ia=%h ib=%h expected acc=%h cf=%b ia=%h ib=%h",
                         tag, dbg_acc, dbg_cf, dbg_ia, dbg_ib, m_acc, m_cf, m_ia, m_ib);
            end else if (dbg_pc !== m_pc) begin
                n_fail++;
                $display("FAIL %s pc (R2 sequencing): actual %h expected %h",
                         (ph != 0 && ph <= 2) ? "R2" : tag, dbg_pc, m_pc);
            end else if (halted !== m_halt) begin
                n_fail++;
                $display("FAIL R9 halted: actual %b expected %b", halted, m_halt);
            end
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(int a, logic [DW-1:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = AW'(a); dbg_wdata = d;
        m_mem[a] = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(string req, int a, logic [DW-1:0] exp);
        @(negedge clk);
        dbg_addr = AW'(a);
        #1;
        check(req, $sformatf("M[%0d]", a), 32'(dbg_rdata), 32'(exp));
        check("R10", $sformatf("M[%0d] vs model", a), 32'(dbg_rdata), 32'(m_mem[a]));
    endtask

    task automatic check_reset();
        check("R1", "pc", 32'(dbg_pc), 0);
        check("R1", "acc", 32'(dbg_acc), 0);
        check("R1", "cf", 32'(dbg_cf), 0);
        check("R1", "ia", 32'(dbg_ia), 0);
        check("R1", "ib", 32'(dbg_ib), 0);
        check("R1", "halted", 32'(halted), 0);
    endtask

    // Run until halt, with a watchdog that counts as a failure.
    task automatic run_prog();
        int cyc = 0;
        @(negedge clk);
        rst_n = 1'b1;
        live_cmp = 1'b1;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        n_tests++;
        if (!halted) begin
            n_fail++;
            $display("FAIL R9 watchdog: halted actual 0 expected 1");
        end
    endtask

    task automatic end_checks();
        check("R5", "final acc", 32'(dbg_acc), 32'h3FFE7);
        check("R5", "final cf", 32'(dbg_cf), 1);
        check("R9", "pc after halt", 32'(dbg_pc), 25);
        check("R4", "ia loaded", 32'(dbg_ia), 2);
        check("R4", "ib loaded", 32'(dbg_ib), 9);
        repeat (10) @(negedge clk);
        check("R9", "pc frozen", 32'(dbg_pc), 25);
        check("R9", "still halted", 32'(halted), 1);
        peek("R8", 110, 18'h3FFF0);
        peek("R7", 50, 18'd14);
        peek("R3", 108, 18'h3FFF0);
        peek("R10", 100, 18'h3FFFF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 256; i++) poke(i, '0);
        // data
        poke(100, 18'h3FFFF);
        poke(101, 18'd103);
        poke(102, 18'd7);
        poke(103, 18'd6);
        poke(104, 18'd9);
        // program
        poke(0,  enc(0, 3, 5));              // LOAD #5
        poke(1,  enc(2, 0, 100));            // ADD M[100] -> carry
        poke(2,  enc(6, 0, 5));              // JC 5 (taken)
        poke(3,  enc(7, 0, 0));              // HALT (skipped)
        poke(4,  enc(7, 0, 0));
        poke(5,  enc(3, 3, 10));             // SUB #10 -> borrow, cf 0
        poke(6,  enc(6, 0, (1 << 11) | 3));  // JC 3 (not taken)
        poke(7,  enc(5, 3, (2 << 11) | 2));  // LDA #2
        poke(8,  enc(0, 2, 100));            // LOAD M[100+IA]
        poke(9,  enc(4, 1, 101));            // AND M[M[101]]
        poke(10, enc(5, 0, 104));            // OR M[104]
        poke(11, enc(5, 0, 1 << 11));        // NOT
        poke(12, enc(1, 0, 110));            // STORE 110
        poke(13, enc(6, 0, (2 << 11) | 50)); // CALL 50
        poke(14, enc(6, 0, 20));             // JMP 20
        poke(15, enc(7, 0, 0));
        poke(20, enc(0, 0, 110));            // LOAD M[110]
        poke(21, enc(5, 3, (3 << 11) | 9));  // LDB #9
        poke(22, enc(1, 2, 106));            // STORE M[106+IA]
        poke(23, enc(3, 0, 104));            // SUB M[104]
        poke(24, enc(7, 0, 0));              // HALT
        poke(51, enc(2, 3, 16));             // ADD #16 -> wraps to 0, cf 1
        poke(52, enc(6, 0, (3 << 11) | 50)); // RET via M[50]
        check_reset();
        run_prog();
        end_checks();
        // second run: reset must clear state left by the first run
        @(negedge clk);
        live_cmp = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset();
        run_prog();
        end_checks();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule